// File: doc/BRIEF.md
# CPU Exception Acceptance Controller

This block sits next to the instruction sequencer of a small CPU core and decides when the core stops normal execution to take an exception. Three sources compete. The release edge of the reset pin has the highest priority. A pending interrupt comes next and carries a vector number from the interrupt controller. A trap instruction has the lowest priority and carries a 2-bit operand. The sequencer reports each instruction boundary and the class of the instruction that just finished. This lets the block keep interrupts out at points where they must not be sampled.

When an interrupt or a trap is accepted, the block pushes the program counter and then the condition codes below the current stack pointer. It issues one stack-write request at a time and waits for the bus handshake on each. It then raises a branch request with the vector-table address. A reset skips the pushes and branches straight to vector 0. When an exception sequence completes, the block can take a waiting interrupt immediately. After a reset, interrupts stay blocked until the first instruction completes.

Top module: `exc_accept_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `exc_mode`, `stk_wr` and `br_req` are 0 and `exc_kind` is 0.
- R2: A low-to-high change of `res_pin_n` seen at a clock edge starts reset handling at that edge, even in the middle of another exception. From the next cycle, `br_req`=1, `vec_addr`=0 and `exc_kind`=1, with no stack write.
- R3: While `res_pin_n` is low, the block stays idle: `exc_mode`, `stk_wr` and `br_req` are 0, and interrupts and traps are not accepted.
- R4: An interrupt (`irq_req`=1) present with `insn_end`=1 in program execution is accepted. The result is `exc_kind`=2 and a vector address of `irq_vec`*4.
- R5: An interrupt is not accepted in a cycle without `insn_end`. It is also not accepted at the end of an instruction of class `insn_cls`=1 (control-register modify). Classes 0, 2 and 3 do not block it.
- R6: After reset handling, the first `insn_end` does not accept an interrupt. A pending interrupt is also not chained at the end of the reset sequence. The next `insn_end` accepts normally.
- R7: `trap_stb` in program execution is always accepted, including under the post-reset block and with class 1. The result is `exc_kind`=3 and a vector address of (`TRAP_BASE`+`trap_op`)*4.
- R8: When sources coincide, the priority is reset, then interrupt, then trap.
- R9: For an interrupt or trap, the program counter is written first at `sp_in`-4 and the condition codes are written next at `sp_in`-8 (zero-extended). Each write is held on `stk_wr`/`stk_addr`/`stk_data` until `stk_ack`, and `stk_wr` and `br_req` are never high together.
- R10: `br_req` and `vec_addr` hold until `br_ack`. In the cycle after `br_ack`, `exc_mode` is 0 unless another exception was accepted.
- R11: An interrupt pending when `br_ack` ends a non-reset sequence is accepted at once, and its program-counter push appears in the next cycle.
- R12: During exception handling, `trap_stb`, `insn_end` and `irq_req` do not change the stack write in progress or `exc_kind`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| res_pin_n | input | 1 | Reset pin, low holds the core; the rising edge starts reset handling |
| irq_req | input | 1 | Interrupt pending from the interrupt controller |
| irq_vec | input | VW | Vector number of the pending interrupt |
| trap_stb | input | 1 | Trap instruction executing |
| trap_op | input | 2 | Trap operand |
| insn_end | input | 1 | Current instruction completes this cycle |
| insn_cls | input | 2 | Class of the finishing instruction, 1 = control-register modify |
| pc_in | input | AW | Program counter to save |
| ccr_in | input | CW | Condition codes to save |
| sp_in | input | AW | Current stack pointer |
| stk_ack | input | 1 | Bus accepted the stack write |
| br_ack | input | 1 | Sequencer took the branch |
| exc_mode | output | 1 | 1 in exception-handling state |
| exc_kind | output | 2 | 0 none, 1 reset, 2 interrupt, 3 trap |
| stk_wr | output | 1 | Stack write request |
| stk_addr | output | AW | Stack write address |
| stk_data | output | AW | Stack write data |
| br_req | output | 1 | Branch through vector table request |
| vec_addr | output | AW | Vector-table address to fetch |

## Verification
A wrong acceptance decision shows on the cycle after the deciding edge. It appears as `stk_wr` or `br_req` rising when it should stay low, or the reverse, or as the wrong `exc_kind`. A stale post-reset block, or a lost one, shows at the first or second `insn_end` after a reset sequence. A wrong push order or stack-pointer step shows on `stk_addr` and `stk_data` one handshake after acceptance, and a wrong vector shows on `vec_addr` when `br_req` rises. Each of these errors is visible at the ports within three cycles of its cause.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_PUSH_PC = 2'd1,
    ST_PUSH_CC = 2'd2,
    ST_BRANCH  = 2'd3
  } exc_state_e;

  typedef enum logic [1:0] {
    EK_NONE  = 2'd0,
    EK_RESET = 2'd1,
    EK_IRQ   = 2'd2,
    EK_TRAP  = 2'd3
  } exc_kind_e;

  localparam logic [1:0] CLS_CTLMOD = 2'd1;
endpackage

// File: rtl/exc_res_edge.sv
module exc_res_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic rise,
  output logic held
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= pin_n;
  end

  assign rise = pin_n & ~prev_q;
  assign held = ~pin_n;

  // R2: a release is seen at one edge only
  a_r2_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int VW        = 8,
  parameter int TRAP_BASE = 8
) (
  input  logic          res_rise,
  input  logic          in_run,
  input  logic          chain_pt,
  input  logic          inhibit,
  input  logic          insn_end,
  input  logic [1:0]    insn_cls,
  input  logic          irq_req,
  input  logic [VW-1:0] irq_vec,
  input  logic          trap_stb,
  input  logic [1:0]    trap_op,
  output exc_kind_e     take,
  output logic [AW-1:0] take_vec
);
  localparam int PADW = AW - VW - 2;

  logic          irq_window;
  logic [VW-1:0] trap_num;

  assign irq_window = ~inhibit &
                      ((in_run & insn_end & (insn_cls != CLS_CTLMOD)) | chain_pt);
  assign trap_num   = VW'(TRAP_BASE) + VW'(trap_op);

  always_comb begin
    take     = EK_NONE;
    take_vec = '0;
    if (res_rise) begin
      take     = EK_RESET;
    end else if (irq_req && irq_window) begin
      take     = EK_IRQ;
      take_vec = {{PADW{1'b0}}, irq_vec, 2'b00};
    end else if (trap_stb && in_run) begin
      take     = EK_TRAP;
      take_vec = {{PADW{1'b0}}, trap_num, 2'b00};
    end
  end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int WB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  exc_kind_e     take,
  input  logic [AW-1:0] take_vec,
  input  logic          insn_end,
  input  logic [AW-1:0] pc_in,
  input  logic [CW-1:0] ccr_in,
  input  logic [AW-1:0] sp_in,
  input  logic          stk_ack,
  input  logic          br_ack,
  output exc_state_e    state,
  output logic          inhibit,
  output logic          stk_wr,
  output logic [AW-1:0] stk_addr,
  output logic [AW-1:0] stk_data,
  output logic          br_req,
  output logic [AW-1:0] vec_addr,
  output exc_kind_e     kind
);
  localparam logic [AW-1:0] STEP = AW'(WB);

  logic [CW-1:0] ccr_q;
  logic [AW-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      state  <= ST_RUN;
      stk_wr <= 1'b0;
      br_req <= 1'b0;
      kind   <= EK_NONE;
      if (rst) begin
        stk_addr <= '0;
        stk_data <= '0;
        vec_addr <= '0;
        vec_q    <= '0;
        ccr_q    <= '0;
      end
    end else if (take == EK_RESET) begin
      state    <= ST_BRANCH;
      kind     <= EK_RESET;
      stk_wr   <= 1'b0;
      br_req   <= 1'b1;
      vec_addr <= '0;
    end else if (take != EK_NONE) begin
      state    <= ST_PUSH_PC;
      kind     <= take;
      vec_q    <= take_vec;
      ccr_q    <= ccr_in;
      stk_wr   <= 1'b1;
      stk_addr <= sp_in - STEP;
      stk_data <= pc_in;
      br_req   <= 1'b0;
    end else begin
      case (state)
        ST_PUSH_PC: if (stk_ack) begin
          state    <= ST_PUSH_CC;
          stk_addr <= stk_addr - STEP;
          stk_data <= {{(AW-CW){1'b0}}, ccr_q};
        end
        ST_PUSH_CC: if (stk_ack) begin
          state    <= ST_BRANCH;
          stk_wr   <= 1'b0;
          br_req   <= 1'b1;
          vec_addr <= vec_q;
        end
        ST_BRANCH: if (br_ack) begin
          state  <= ST_RUN;
          br_req <= 1'b0;
          kind   <= EK_NONE;
        end
        default: ;
      endcase
    end
  end

  // post-reset interrupt block: set by reset handling, cleared by first instruction end
  always_ff @(posedge clk) begin
    if (rst || hold)                       inhibit <= 1'b0;
    else if (take == EK_RESET)             inhibit <= 1'b1;
    else if (state == ST_RUN && insn_end)  inhibit <= 1'b0;
  end

  a_r9_exclusive_req: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stk_wr, br_req}));

  a_r9_second_push_below: assert property (@(posedge clk) disable iff (rst || hold)
    (state == ST_PUSH_PC && stk_ack && take == EK_NONE) |=>
      (stk_addr == $past(stk_addr) - STEP));

  a_r10_branch_held: assert property (@(posedge clk) disable iff (rst || hold)
    (br_req && !br_ack && take == EK_NONE) |=> (br_req && $stable(vec_addr)));

  a_r2_reset_no_push: assert property (@(posedge clk) disable iff (rst)
    (kind == EK_RESET) |-> !stk_wr);
endmodule

// File: rtl/exc_accept_ctrl.sv
module exc_accept_ctrl
  import exc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int VW        = 8,
  parameter int CW        = 8,
  parameter int WB        = 4,
  parameter int TRAP_BASE = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          res_pin_n,
  input  logic          irq_req,
  input  logic [VW-1:0] irq_vec,
  input  logic          trap_stb,
  input  logic [1:0]    trap_op,
  input  logic          insn_end,
  input  logic [1:0]    insn_cls,
  input  logic [AW-1:0] pc_in,
  input  logic [CW-1:0] ccr_in,
  input  logic [AW-1:0] sp_in,
  input  logic          stk_ack,
  input  logic          br_ack,
  output logic          exc_mode,
  output logic [1:0]    exc_kind,
  output logic          stk_wr,
  output logic [AW-1:0] stk_addr,
  output logic [AW-1:0] stk_data,
  output logic          br_req,
  output logic [AW-1:0] vec_addr
);
  logic          res_rise, res_held, inhibit;
  exc_state_e    state;
  exc_kind_e     take, kind;
  logic [AW-1:0] take_vec;

  exc_res_edge u_edge (
    .clk(clk), .rst(rst), .pin_n(res_pin_n), .rise(res_rise), .held(res_held)
  );

  exc_arbiter #(.AW(AW), .VW(VW), .TRAP_BASE(TRAP_BASE)) u_arb (
    .res_rise(res_rise),
    .in_run(state == ST_RUN),
    .chain_pt(state == ST_BRANCH && br_ack),
    .inhibit(inhibit),
    .insn_end(insn_end),
    .insn_cls(insn_cls),
    .irq_req(irq_req),
    .irq_vec(irq_vec),
    .trap_stb(trap_stb),
    .trap_op(trap_op),
    .take(take),
    .take_vec(take_vec)
  );

  exc_seq #(.AW(AW), .CW(CW), .WB(WB)) u_seq (
    .clk(clk), .rst(rst), .hold(res_held),
    .take(take), .take_vec(take_vec), .insn_end(insn_end),
    .pc_in(pc_in), .ccr_in(ccr_in), .sp_in(sp_in),
    .stk_ack(stk_ack), .br_ack(br_ack),
    .state(state), .inhibit(inhibit),
    .stk_wr(stk_wr), .stk_addr(stk_addr), .stk_data(stk_data),
    .br_req(br_req), .vec_addr(vec_addr), .kind(kind)
  );

  assign exc_mode = (state != ST_RUN);
  assign exc_kind = kind;

  a_r5_ctl_class_blocks_irq: assert property (@(posedge clk) disable iff (rst)
    (!exc_mode && insn_end && insn_cls == CLS_CTLMOD) |=> (exc_kind != 2'd2));

  a_r12_push_unaffected: assert property (@(posedge clk) disable iff (rst)
    (stk_wr && !stk_ack && res_pin_n && !res_rise) |=>
      ($stable(exc_kind) && $stable(stk_addr) && $stable(stk_data)));

  a_r3_idle_while_held: assert property (@(posedge clk) disable iff (rst)
    (!res_pin_n) |=> (!stk_wr && !br_req));
endmodule

// File: tb/exc_accept_ctrl_bench.sv
module exc_accept_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int VW = 8;
  localparam int CW = 8;

  typedef struct packed {
    logic       irq;
    logic       iend;
    logic [1:0] cls;
    logic       trap;
    logic [1:0] op;
    logic [7:0] vec;
    logic [1:0] ekind;
    logic [31:0] evec;
    logic [3:0] req;
  } row_t;

  // irq iend cls trap op vec kind vector req
  localparam row_t ROWS [7] = '{
    '{1'b1, 1'b1, 2'd0, 1'b0, 2'd0, 8'h40, 2'd2, 32'h100, 4'd4},  // R4 plain end
    '{1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 8'h41, 2'd0, 32'h0,   4'd5},  // R5 no end
    '{1'b1, 1'b1, 2'd1, 1'b0, 2'd0, 8'h42, 2'd0, 32'h0,   4'd5},  // R5 ctl class
    '{1'b0, 1'b0, 2'd0, 1'b1, 2'd2, 8'h00, 2'd3, 32'h28,  4'd7},  // R7 trap op 2
    '{1'b1, 1'b1, 2'd0, 1'b1, 2'd1, 8'h21, 2'd2, 32'h84,  4'd8},  // R8 irq beats trap
    '{1'b1, 1'b1, 2'd1, 1'b1, 2'd3, 8'h22, 2'd3, 32'h2C,  4'd7},  // R7 trap under ctl class
    '{1'b1, 1'b1, 2'd2, 1'b0, 2'd0, 8'h07, 2'd2, 32'h1C,  4'd5}   // R5 class 2 not blocking
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic res_pin_n = 1'b1;
  logic irq_req = 1'b0;
  logic [VW-1:0] irq_vec = '0;
  logic trap_stb = 1'b0;
  logic [1:0] trap_op = '0;
  logic insn_end = 1'b0;
  logic [1:0] insn_cls = '0;
  logic [AW-1:0] pc_in = '0;
  logic [CW-1:0] ccr_in = '0;
  logic [AW-1:0] sp_in = '0;
  logic stk_ack = 1'b0;
  logic br_ack = 1'b0;
  logic exc_mode, stk_wr, br_req;
  logic [1:0] exc_kind;
  logic [AW-1:0] stk_addr, stk_data, vec_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_accept_ctrl u_exc_accept_ctrl (
    .clk(clk), .rst(rst), .res_pin_n(res_pin_n),
    .irq_req(irq_req), .irq_vec(irq_vec), .trap_stb(trap_stb), .trap_op(trap_op),
    .insn_end(insn_end), .insn_cls(insn_cls),
    .pc_in(pc_in), .ccr_in(ccr_in), .sp_in(sp_in),
    .stk_ack(stk_ack), .br_ack(br_ack),
    .exc_mode(exc_mode), .exc_kind(exc_kind), .stk_wr(stk_wr),
    .stk_addr(stk_addr), .stk_data(stk_data), .br_req(br_req), .vec_addr(vec_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clear_strobes();
    irq_req = 1'b0; insn_end = 1'b0; trap_stb = 1'b0; insn_cls = 2'd0;
  endtask

  // called in the cycle after acceptance of an interrupt or trap
  task automatic walk_push(input string tag, input logic [31:0] sp, input logic [31:0] pc,
                           input logic [7:0] ccr, input logic [1:0] kind, input logic [31:0] vec);
    chk({tag, " R9 pc push wr"}, 32'(stk_wr), 32'd1);
    chk({tag, " R9 pc addr"}, stk_addr, sp - 32'd4);
    chk({tag, " R9 pc data"}, stk_data, pc);
    chk({tag, " kind"}, 32'(exc_kind), 32'(kind));
    cyc();
    chk({tag, " R9 held without ack"}, stk_addr, sp - 32'd4);
    stk_ack = 1'b1; cyc(); stk_ack = 1'b0;
    chk({tag, " R9 ccr addr"}, stk_addr, sp - 32'd8);
    chk({tag, " R9 ccr data"}, stk_data, 32'(ccr));
    chk({tag, " R9 br low"}, 32'(br_req), 32'd0);
    stk_ack = 1'b1; cyc(); stk_ack = 1'b0;
    chk({tag, " R9 wr drops"}, 32'(stk_wr), 32'd0);
    chk({tag, " R10 br req"}, 32'(br_req), 32'd1);
    chk({tag, " vector"}, vec_addr, vec);
    cyc();
    chk({tag, " R10 br held"}, 32'(br_req), 32'd1);
  endtask

  task automatic finish_branch(input string tag);
    br_ack = 1'b1; cyc(); br_ack = 1'b0;
    chk({tag, " R10 back to run"}, 32'(exc_mode), 32'd0);
    chk({tag, " R10 br dropped"}, 32'(br_req), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    chk("R1 mode in reset", 32'(exc_mode), 32'd0);
    chk("R1 kind in reset", 32'(exc_kind), 32'd0);
    rst = 1'b0;
    cyc();
    chk("R1 wr after reset", 32'(stk_wr), 32'd0);
    chk("R1 br after reset", 32'(br_req), 32'd0);

    // table walk
    for (int i = 0; i < 7; i++) begin
      string tag;
      logic [31:0] sp, pc;
      logic [7:0] ccr;
      tag = $sformatf("R%0d row%0d", ROWS[i].req, i);
      sp  = 32'h8000 - 32'(i * 32);
      pc  = 32'h1000 + 32'(i * 16);
      ccr = 8'h80 | 8'(i);
      irq_req = ROWS[i].irq; insn_end = ROWS[i].iend; insn_cls = ROWS[i].cls;
      trap_stb = ROWS[i].trap; trap_op = ROWS[i].op; irq_vec = ROWS[i].vec;
      sp_in = sp; pc_in = pc; ccr_in = ccr;
      cyc();
      clear_strobes();
      if (ROWS[i].ekind == 2'd0) begin
        chk({tag, " not taken"}, 32'(exc_mode), 32'd0);
        chk({tag, " no write"}, 32'(stk_wr), 32'd0);
      end else begin
        walk_push(tag, sp, pc, ccr, ROWS[i].ekind, ROWS[i].evec);
        finish_branch(tag);
      end
    end

    // R12: strobes during a push have no effect
    sp_in = 32'h4000; pc_in = 32'h2222; ccr_in = 8'h5A;
    trap_stb = 1'b1; trap_op = 2'd1; cyc(); clear_strobes();
    trap_stb = 1'b1; trap_op = 2'd3; irq_req = 1'b1; insn_end = 1'b1; irq_vec = 8'h10;
    pc_in = 32'h9999;
    cyc(); clear_strobes();
    chk("R12 kind kept", 32'(exc_kind), 32'd3);
    chk("R12 addr kept", stk_addr, 32'h3FFC);
    chk("R12 data kept", stk_data, 32'h2222);
    walk_push("R12 rest", 32'h4000, 32'h2222, 8'h5A, 2'd3, 32'h24);
    finish_branch("R12");

    // R11: interrupt chained at end of a trap sequence
    sp_in = 32'h5000; pc_in = 32'h3000; ccr_in = 8'h11;
    trap_stb = 1'b1; trap_op = 2'd0; cyc(); clear_strobes();
    walk_push("R11 trap", 32'h5000, 32'h3000, 8'h11, 2'd3, 32'h20);
    irq_req = 1'b1; irq_vec = 8'h33; pc_in = 32'h3100;
    br_ack = 1'b1; cyc(); br_ack = 1'b0; irq_req = 1'b0;
    chk("R11 chained push", 32'(stk_wr), 32'd1);
    chk("R11 chained kind", 32'(exc_kind), 32'd2);
    walk_push("R11 irq", 32'h5000, 32'h3100, 8'h11, 2'd2, 32'hCC);
    finish_branch("R11");

    // R3: pin held low keeps the block idle
    res_pin_n = 1'b0; cyc();
    trap_stb = 1'b1; irq_req = 1'b1; insn_end = 1'b1; cyc(); clear_strobes();
    chk("R3 no write while held", 32'(stk_wr), 32'd0);
    chk("R3 no mode while held", 32'(exc_mode), 32'd0);
    // R2 + R8: release wins over a simultaneous interrupt
    res_pin_n = 1'b1; irq_req = 1'b1; insn_end = 1'b1; cyc(); clear_strobes();
    chk("R2 br req", 32'(br_req), 32'd1);
    chk("R2 vector 0", vec_addr, 32'd0);
    chk("R8 R2 kind reset", 32'(exc_kind), 32'd1);
    chk("R2 no stack write", 32'(stk_wr), 32'd0);
    // R6: no chain at end of reset sequence
    irq_req = 1'b1; irq_vec = 8'h05;
    br_ack = 1'b1; cyc(); br_ack = 1'b0;
    chk("R6 no chain after reset", 32'(exc_mode), 32'd0);
    insn_end = 1'b1; cyc(); clear_strobes();
    chk("R6 first end blocked", 32'(exc_mode), 32'd0);
    irq_req = 1'b1; insn_end = 1'b1; sp_in = 32'h6000; pc_in = 32'h44; ccr_in = 8'h02;
    cyc(); clear_strobes();
    walk_push("R6 second end", 32'h6000, 32'h44, 8'h02, 2'd2, 32'h14);
    finish_branch("R6");

    // R7: trap accepted while post-reset block is active
    res_pin_n = 1'b0; cyc(); res_pin_n = 1'b1; cyc();
    br_ack = 1'b1; cyc(); br_ack = 1'b0;
    trap_stb = 1'b1; trap_op = 2'd2; sp_in = 32'h7000; pc_in = 32'h55; ccr_in = 8'h03;
    cyc(); clear_strobes();
    walk_push("R7 under block", 32'h7000, 32'h55, 8'h03, 2'd3, 32'h28);
    finish_branch("R7");

    // R2: release in the middle of a push restarts with reset
    trap_stb = 1'b1; trap_op = 2'd0; cyc(); clear_strobes();
    chk("R2 push started", 32'(stk_wr), 32'd1);
    res_pin_n = 1'b0; cyc();
    res_pin_n = 1'b1; cyc();
    chk("R2 mid reset br", 32'(br_req), 32'd1);
    chk("R2 mid reset kind", 32'(exc_kind), 32'd1);
    chk("R2 mid reset no wr", 32'(stk_wr), 32'd0);
    finish_branch("R2 mid");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule